// File: doc/BRIEF.md
# Latched Maskable Interrupt Controller

This block collects a set of event inputs and drives one active-high interrupt request line to a host processor. Each event input is first filtered by its own debounce counter, which advances only on a slow enable strobe; an input must hold a new level for that source's full debounce period before the filtered level follows it. When a filtered level goes from 0 to 1, a sticky status bit is set for that source. The bit stays set until the host clears it.

The host works through two write strobes that share one data word. The status write clears every status bit whose data bit is 1. The mask write loads the mask register. A mask bit of 1 keeps its source off the interrupt line, but the status bit still sets and can be read on the status output for polling. Reset leaves every source masked and every status bit clear. The request line is the OR of all status bits whose mask bit is 0, taken from the registered state. It therefore changes on the same clock edge as the status or mask register.

Top module: `irq_latch_ctrl`

## Requirements
- R1: `irq_o` is 1 exactly when some bit is 1 in `stat_o` and 0 in `mask_o`. It follows those registers with no extra cycle of delay.
- R2: A status bit that is set stays set after its event input returns to 0, until a status write with a 1 in that bit position clears it.
- R3: A status write (`wr_stat_i`=1) clears, at that clock edge, every status bit where `wr_data_i` is 1. If no other unmasked bit remains set, `irq_o` goes to 0.
- R4: A status write leaves unchanged every status bit where `wr_data_i` is 0.
- R5: If a debounced rising event and a clearing status write reach the same bit on the same edge, the bit ends up set.
- R6: If one unmasked bit is set on the same edge at which the only other pending unmasked bit is cleared, `irq_o` stays 1 before and after that edge.
- R7: A source whose mask bit is 1 does not drive `irq_o`, but its status bit still sets and shows on `stat_o`.
- R8: While `rst_n` is 0, `stat_o` is all zeros, `mask_o` is all ones and `irq_o` is 0.
- R9: A mask write (`wr_mask_i`=1) loads `wr_data_i` into the mask at that edge. Clearing the mask bit of a status bit that is already set raises `irq_o` right after that edge.
- R10: Each input is registered once per clock. Call the edge at which the registered value first differs from the debounced level edge E. The debounced level takes the new value at the PERIOD-th later edge on which `tick_en_i` is 1, where PERIOD is that source's period. With `tick_en_i` held at 1, this is edge E+PERIOD. The status bit sets on that same edge. If the input returns to the debounced level before expiry, the count starts again from zero. With the default parameters, source i has a period of 8-i ticks.
- R11: Only a 0-to-1 change of the debounced level sets a status bit. A 1-to-0 change, or an input that stays high after its bit was cleared, sets nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Slow enable strobe that paces the debounce counters |
| evt_i | input | NSRC | Raw event inputs, one per source |
| wr_stat_i | input | 1 | Status write strobe, write-1-to-clear |
| wr_mask_i | input | 1 | Mask write strobe, loads the mask |
| wr_data_i | input | NSRC | Data word for both write strobes |
| stat_o | output | NSRC | Sticky status register |
| mask_o | output | NSRC | Mask register, 1 = blocked |
| irq_o | output | 1 | Interrupt request line, active high |

## Verification
The bench targets the races. In the set-versus-clear race on one bit, a design that lets the clear win loses the event. In the clear-on-one, set-on-another race, a design that builds the line from stale state drops `irq_o` for a cycle. It unmasks a bit that is already pending, which catches a line that waits for a fresh event. It drops an input for one sample during a slow debounce, which catches a counter that does not restart and fires several edges too early. It also drives an input that stays high after its bit was cleared, which catches a filter that sets on level instead of on a rising edge. Random events, ticks and writes are then compared every cycle against a bench model of the rules above.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Width of a debounce counter that must reach period-1
    function automatic int unsigned irq_cnt_width(input int unsigned period);
        return (period > 1) ? $clog2(period) : 1;
    endfunction

    // Default period field width and source count
    localparam int unsigned IRQ_PER_W_DEF = 4;
    localparam int unsigned IRQ_NSRC_DEF  = 8;

endpackage

// File: rtl/irq_debounce.sv
module irq_debounce
    import irq_pkg::*;
#(
    parameter int unsigned PERIOD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en_i,
    input  logic evt_i,
    output logic rise_o
);
    localparam int unsigned CW = irq_cnt_width(PERIOD);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    typedef struct packed {
        logic          samp;
        logic          stab;
        logic [CW-1:0] cnt;
    } db_state_t;

    db_state_t st_d, st_q;
    logic      rise_d;

    always_comb begin
        st_d      = st_q;
        rise_d    = 1'b0;
        st_d.samp = evt_i;
        if (st_q.samp == st_q.stab) begin
            st_d.cnt = '0;
        end else if (tick_en_i) begin
            if (st_q.cnt == LAST) begin
                st_d.stab = st_q.samp;
                st_d.cnt  = '0;
                rise_d    = st_q.samp;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = rise_d;

    // R10: filtered level moves only on a tick
    a_r10_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en_i |=> $stable(st_q.stab));

    // R10: counter never passes its limit
    a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

    // R11: only an upward change of the filtered level reports an event
    a_r11_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> st_q.stab);

endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs #(
    parameter int unsigned NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic            wr_stat_i,
    input  logic            wr_mask_i,
    input  logic [NSRC-1:0] wr_data_i,
    output logic [NSRC-1:0] stat_o,
    output logic [NSRC-1:0] mask_o
);
    typedef struct packed {
        logic [NSRC-1:0] stat;
        logic [NSRC-1:0] mask;
    } regs_t;

    regs_t           rg_d, rg_q;
    logic [NSRC-1:0] clr_d;

    always_comb begin
        rg_d      = rg_q;
        clr_d     = wr_stat_i ? wr_data_i : '0;
        rg_d.stat = (rg_q.stat & ~clr_d) | set_i;
        if (wr_mask_i) begin
            rg_d.mask = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q.stat <= '0;
            rg_q.mask <= '1;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign stat_o = rg_q.stat;
    assign mask_o = rg_q.mask;

    // R2/R4: bits not cleared by a write survive
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & $past(stat_o & ~(wr_stat_i ? wr_data_i : '0)))
                  == $past(stat_o & ~(wr_stat_i ? wr_data_i : '0))));

    // R3: written ones clear unless an event arrives
    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat_i |=> ((stat_o & $past(wr_data_i & ~set_i)) == '0));

    // R5: an event always lands
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((stat_o & $past(set_i)) == $past(set_i)));

    // R8: reset masks everything and clears status
    a_r8_reset_vals: assert property (@(posedge clk)
        !rst_n |=> ((&mask_o) && (stat_o == '0)));

endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned NSRC  = IRQ_NSRC_DEF,
    parameter int unsigned PER_W = IRQ_PER_W_DEF,
    parameter logic [NSRC*PER_W-1:0] DB_PERIODS =
        {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8}
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en_i,
    input  logic [NSRC-1:0] evt_i,
    input  logic            wr_stat_i,
    input  logic            wr_mask_i,
    input  logic [NSRC-1:0] wr_data_i,
    output logic [NSRC-1:0] stat_o,
    output logic [NSRC-1:0] mask_o,
    output logic            irq_o
);
    logic [NSRC-1:0] set_bits;
    logic            irq_d;

    for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
        localparam int unsigned P_RAW = int'(DB_PERIODS[gi*PER_W +: PER_W]);
        localparam int unsigned P_EFF = (P_RAW == 0) ? 1 : P_RAW;

        irq_debounce #(.PERIOD(P_EFF)) u_db (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_en_i(tick_en_i),
            .evt_i    (evt_i[gi]),
            .rise_o   (set_bits[gi])
        );
    end

    irq_status_regs #(.NSRC(NSRC)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_bits),
        .wr_stat_i(wr_stat_i),
        .wr_mask_i(wr_mask_i),
        .wr_data_i(wr_data_i),
        .stat_o   (stat_o),
        .mask_o   (mask_o)
    );

    always_comb begin
        irq_d = |(stat_o & ~mask_o);
    end

    assign irq_o = irq_d;

    // R9: unmasking a pending bit raises the line after the write edge
    a_r9_unmask_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask_i && !wr_stat_i && |(stat_o & ~wr_data_i)) |=> irq_o);

    // R6: an unmasked event keeps the line up even during a clear
    a_r6_race_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_mask_i && |(set_bits & ~mask_o)) |=> irq_o);

    // R7: with every source masked the line is low
    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_o) |-> !irq_o);

endmodule

// File: tb/sim_irq_latch_ctrl.sv
module sim_irq_latch_ctrl;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic [N-1:0] evt = '0;
    logic         wr_stat = 1'b0;
    logic         wr_mask = 1'b0;
    logic [N-1:0] wr_data = '0;
    logic [N-1:0] stat_o, mask_o;
    logic         irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    bit cmp_en = 0;

    always #2 clk = ~clk;

    irq_latch_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en), .evt_i(evt),
        .wr_stat_i(wr_stat), .wr_mask_i(wr_mask), .wr_data_i(wr_data),
        .stat_o(stat_o), .mask_o(mask_o), .irq_o(irq_o)
    );

    function automatic int per_of(input int i);
        return 8 - i;
    endfunction

    function automatic logic exp_line(input logic [N-1:0] s, input logic [N-1:0] m);
        return |(s & ~m);
    endfunction

    // Reference model of the requirements
    logic [N-1:0] m_samp, m_stab, m_stat, m_mask;
    int           m_cnt [N];

    always @(posedge clk) begin
        logic [N-1:0] setv;
        if (!rst_n) begin
            m_samp = '0; m_stab = '0; m_stat = '0; m_mask = '1;
            for (int i = 0; i < N; i++) m_cnt[i] = 0;
        end else begin
            setv = '0;
            for (int i = 0; i < N; i++) begin
                if (m_samp[i] == m_stab[i]) m_cnt[i] = 0;
                else if (tick_en) begin
                    if (m_cnt[i] == per_of(i) - 1) begin
                        m_stab[i] = m_samp[i];
                        m_cnt[i] = 0;
                        setv[i] = m_samp[i];
                    end else m_cnt[i] = m_cnt[i] + 1;
                end
                m_samp[i] = evt[i];
            end
            m_stat = (m_stat & ~(wr_stat ? wr_data : '0)) | setv;
            if (wr_mask) m_mask = wr_data;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk("R1/R2/R10 model stat", 32'(stat_o), 32'(m_stat));
            chk("R9 model mask", 32'(mask_o), 32'(m_mask));
            chk("R1 model irq", 32'(irq_o), 32'(exp_line(m_stat, m_mask)));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        cyc(3);
        chk("R8 reset stat", 32'(stat_o), 0);
        chk("R8 reset mask", 32'(mask_o), 32'hFF);
        chk("R8 reset irq", 32'(irq_o), 0);
        rst_n = 1'b1;
        tick_en = 1'b1;
        cyc(1);

        // R10: period 1 (src7) and period 8 (src0)
        evt[7] = 1'b1; evt[0] = 1'b1;
        cyc(1);
        chk("R10 nothing at E", 32'(stat_o), 0);
        cyc(1);
        chk("R10 src7 at E+1", 32'(stat_o), 32'h80);
        chk("R7 masked line low", 32'(irq_o), 0);
        cyc(6);
        chk("R10 src0 not yet at E+7", 32'(stat_o[0]), 0);
        cyc(1);
        chk("R10 src0 at E+8", 32'(stat_o), 32'h81);

        // R9: unmask pending bit
        wr_mask = 1'b1; wr_data = 8'h7F;
        cyc(1);
        wr_mask = 1'b0;
        chk("R9 mask loaded", 32'(mask_o), 32'h7F);
        chk("R9 line up after unmask", 32'(irq_o), 1);

        // R4: write of zeros
        wr_stat = 1'b1; wr_data = 8'h00;
        cyc(1);
        wr_stat = 1'b0;
        chk("R4 zero write no effect", 32'(stat_o), 32'h81);

        // R3: clear src7, line falls (src0 masked)
        wr_stat = 1'b1; wr_data = 8'h80;
        cyc(1);
        wr_stat = 1'b0;
        chk("R3 cleared", 32'(stat_o), 32'h01);
        chk("R3 line low", 32'(irq_o), 0);
        cyc(3);
        chk("R11 held high no reset", 32'(stat_o), 32'h01);

        // R11 / R2: falling level sets nothing
        evt[7] = 1'b0;
        cyc(5);
        chk("R11 fall sets nothing", 32'(stat_o), 32'h01);

        // R10 restart: src1 period 7
        evt[1] = 1'b1;
        cyc(3);
        evt[1] = 1'b0;
        cyc(1);
        evt[1] = 1'b1;
        cyc(7);
        chk("R10 restart not yet", 32'(stat_o[1]), 0);
        cyc(1);
        chk("R10 restart expiry", 32'(stat_o[1]), 1);
        evt[1] = 1'b0;

        // R5: set and clear on src7 same edge
        evt[7] = 1'b1;
        cyc(1);
        wr_stat = 1'b1; wr_data = 8'h80;
        cyc(1);
        wr_stat = 1'b0;
        chk("R5 set wins", 32'(stat_o[7]), 1);

        // R6: clear src7 while src6 (period 2) sets
        wr_mask = 1'b1; wr_data = 8'h3F;
        cyc(1);
        wr_mask = 1'b0;
        evt[6] = 1'b1;
        cyc(2);
        chk("R6 line before race", 32'(irq_o), 1);
        wr_stat = 1'b1; wr_data = 8'h80;
        cyc(1);
        wr_stat = 1'b0;
        chk("R6 line after race", 32'(irq_o), 1);
        chk("R6 stat after race", 32'(stat_o[7:6]), 32'h1);

        // R1/R7: clear src6, only masked bits remain
        wr_stat = 1'b1; wr_data = 8'h40;
        cyc(1);
        wr_stat = 1'b0;
        chk("R7 masked bits readable", 32'(stat_o), 32'h03);
        chk("R1 line low", 32'(irq_o), 0);

        // Random phase against the model
        cmp_en = 1'b1;
        for (int k = 0; k < 3000; k++) begin
            for (int i = 0; i < N; i++)
                if ($urandom % 8 == 0) evt[i] = ~evt[i];
            tick_en = ($urandom % 3 == 0);
            wr_stat = ($urandom % 10 == 0);
            wr_mask = ($urandom % 20 == 0);
            wr_data = 8'($urandom);
            cyc(1);
        end
        wr_stat = 1'b0; wr_mask = 1'b0;
        cyc(2);
        done = 1;
        finish_run();
    end
endmodule